// File: doc/BRIEF.md
# Prescaled Periodic Tick Timer

This block raises a periodic tick interrupt from a 32768 Hz reference, supplied as a one-cycle strobe `ref_stb` in the system clock domain. A 4-bit select field in the control register sets a power-of-two prescale, so the counter advances once every 2^sel reference strobes. A programmable reload value sets how many prescaled steps make one tick period. When the down-counter finishes a period it reloads, keeps running, and latches a pending interrupt. Software clears that interrupt by writing a one to the status register.

Software writes a master enable, a tick enable and the prescale select through a small write port. The counter starts only when a control write turns the tick enable on while the master enable in the same write is set. Either enable going low stops it. The current count, the stored reload value, the control contents and the interrupt line are all visible at the ports.

Top module: `tick_timer`

## Requirements
- R1: After reset the control outputs are zero, the reload value equals parameter RST_RELOAD (32), the count is zero and the interrupt is low.
- R2: A write to address 0 stores bit 0 as the master enable, bits 7:4 as the prescale select and bit 8 as the tick enable. All other control bits read as zero.
- R3: A write to address 1 replaces the reload value only when the written value is greater than 2. A value of 0, 1 or 2 leaves the old reload value in place.
- R4: A control write that sets the tick enable from 0 to 1, with the master enable set in the same write, loads the count with the reload value on the next cycle and starts counting. Setting the master enable while the tick enable is already 1 does not start the counter.
- R5: A control write that clears the tick enable, or clears a previously set master enable, stops the counter. The count then holds its value.
- R6: While running, the count decreases by one every 2^sel reference strobes, and stays unchanged between those strobes.
- R7: A prescaled step taken while the count is 1 reloads the count with the reload value and sets the interrupt. The counter keeps running.
- R8: A write to address 2 with bit 0 set clears the interrupt. With bit 0 clear the write has no effect. An expiry in the same cycle as the clear leaves the interrupt set.
- R9: Starting the counter, or a control write that changes the prescale select, restarts the prescale phase. The next step then comes a full 2^sel strobes later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_stb | input | 1 | One-cycle strobe at 32768 Hz |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 reload, 2 interrupt status |
| wr_data | input | CNT_W | Write data |
| ctrl_o | output | 9 | Stored control bits |
| reload_o | output | CNT_W | Stored reload value |
| count_o | output | CNT_W | Current down-count |
| tick_irq | output | 1 | Tick interrupt, same as the pending status bit |

## Verification
Some properties are checked on every cycle. The count changes only on a load or a prescaled step. A load or an expiry always leaves the reload value in the count. A select of zero steps on every strobe while running. The reload register changes only through an accepted write. The interrupt rises only on an expiry.

Other behaviour depends on a history of writes, so only the bench scenarios show it. These cases are:
- rejecting small reload values;
- a master-enable return that does not restart the counter;
- the count freezing after each kind of stop;
- the phase restart after a select change.

A behavioural model follows all of these on every clock.

// File: rtl/tick_timer_pkg.sv
`timescale 1ns/1ps
package tick_timer_pkg;
  localparam int SEL_W   = 4;
  localparam int PH_W    = (1 << SEL_W) - 1;
  localparam int CTL_W   = 9;
  localparam int EN_BIT  = 0;
  localparam int SEL_LSB = 4;
  localparam int TEN_BIT = 8;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_RELOAD = 2'd1,
    REG_STATUS = 2'd2
  } reg_sel_e;

  // all-ones over the low sel bits of the phase counter
  function automatic logic [PH_W-1:0] phase_mask(input logic [SEL_W-1:0] sel);
    phase_mask = PH_W'((32'd1 << sel) - 32'd1);
  endfunction

  // smallest accepted reload is 3
  function automatic logic reload_ok(input logic [31:0] v);
    reload_ok = (v > 32'd2);
  endfunction
endpackage

// File: rtl/tick_prescaler.sv
`timescale 1ns/1ps
module tick_prescaler
  import tick_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_stb_i,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             pulse_o
);
  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] mask;

  always_comb begin
    mask    = phase_mask(sel_i);
    pulse_o = ref_stb_i && run_i && ((phase_q & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  phase_q <= '0;
    else if (clr_i)              phase_q <= '0;
    else if (ref_stb_i && run_i) phase_q <= phase_q + 1'b1;
  end

  // R6
  sel_zero_every_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && ref_stb_i && sel_i == '0) |-> pulse_o);
  // R9
  phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (phase_q == '0));
endmodule

// File: rtl/tick_downcounter.sv
`timescale 1ns/1ps
module tick_downcounter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             stop_i,
  input  logic             pulse_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             run_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

  assign expire_o = run_o && pulse_i && (count_o == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_o   <= 1'b0;
      count_o <= '0;
    end else if (load_i) begin
      run_o   <= 1'b1;
      count_o <= reload_i;
    end else if (stop_i) begin
      run_o   <= 1'b0;
    end else if (run_o && pulse_i) begin
      count_o <= expire_o ? reload_i : count_o - 1'b1;
    end
  end

  // R6
  count_moves_only_on_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !pulse_i) |=> $stable(count_o));
  // R4
  load_takes_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (count_o == $past(reload_i)));
  // R7
  expire_reloads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !load_i && !stop_i) |=> (count_o == $past(reload_i) && run_o));
endmodule

// File: rtl/tick_timer.sv
`timescale 1ns/1ps
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int RST_RELOAD = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_stb,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [8:0]       ctrl_o,
  output logic [CNT_W-1:0] reload_o,
  output logic [CNT_W-1:0] count_o,
  output logic             tick_irq
);
  logic             wr_ctrl, wr_reload, wr_status;
  logic             new_en, new_ten;
  logic [SEL_W-1:0] new_sel, cur_sel;
  logic             start, stop, sel_chg, ph_clr;
  logic             step, expire, running;
  logic [CTL_W-1:0] ctrl_n;

  always_comb begin
    wr_ctrl   = wr_en && (wr_addr == REG_CTRL);
    wr_reload = wr_en && (wr_addr == REG_RELOAD);
    wr_status = wr_en && (wr_addr == REG_STATUS);
    new_en    = wr_data[EN_BIT];
    new_ten   = wr_data[TEN_BIT];
    new_sel   = wr_data[SEL_LSB +: SEL_W];
    cur_sel   = ctrl_o[SEL_LSB +: SEL_W];
    start     = wr_ctrl && new_en && new_ten && !ctrl_o[TEN_BIT];
    stop      = wr_ctrl && ((!new_ten && ctrl_o[TEN_BIT]) || (!new_en && ctrl_o[EN_BIT]));
    sel_chg   = wr_ctrl && (new_sel != cur_sel);
    ph_clr    = start || sel_chg;
    ctrl_n    = '0;
    ctrl_n[EN_BIT]              = new_en;
    ctrl_n[TEN_BIT]             = new_ten;
    ctrl_n[SEL_LSB +: SEL_W]    = new_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_o   <= '0;
      reload_o <= CNT_W'(RST_RELOAD);
      tick_irq <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_o <= ctrl_n;
      if (wr_reload && reload_ok(32'(wr_data))) reload_o <= wr_data;
      if (expire) tick_irq <= 1'b1;
      else if (wr_status && wr_data[0]) tick_irq <= 1'b0;
    end
  end

  tick_prescaler u_presc (
    .clk(clk), .rst_n(rst_n), .ref_stb_i(ref_stb), .run_i(running),
    .clr_i(ph_clr), .sel_i(cur_sel), .pulse_o(step)
  );

  tick_downcounter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_i(start), .stop_i(stop), .pulse_i(step),
    .reload_i(reload_o), .count_o(count_o), .run_o(running), .expire_o(expire)
  );

  // R3
  reload_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reload_o) |-> $past(wr_en && wr_addr == 2'd1 && wr_data > CNT_W'(2)));
  // R7
  irq_from_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tick_irq) |-> $past(expire));
  // R5
  run_needs_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (ctrl_o[EN_BIT] && ctrl_o[TEN_BIT]));
endmodule

// File: tb/tb_tick_timer.sv
`timescale 1ns/1ps
module tb_tick_timer;
  localparam int CNT_W = 16;
  logic clk = 0, rst_n = 0, ref_stb = 0, wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [CNT_W-1:0] wr_data = 0;
  logic [8:0] ctrl_o;
  logic [CNT_W-1:0] reload_o, count_o;
  logic tick_irq;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  tick_timer #(.CNT_W(CNT_W), .RST_RELOAD(32)) dut (
    .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl_o(ctrl_o), .reload_o(reload_o), .count_o(count_o),
    .tick_irq(tick_irq)
  );

  always #10 clk = ~clk;

  // behavioural reference
  int m_en, m_ten, m_sel, m_reload, m_cnt, m_run, m_pend, m_phase, m_irqs;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_ten = 0; m_sel = 0; m_reload = 32; m_cnt = 0;
      m_run = 0; m_pend = 0; m_phase = 0; m_irqs = 0;
    end else begin
      int per, w, nen, nten, nsel;
      bit pulse, exp_now;
      per = 1 << m_sel;
      pulse = ref_stb && m_run != 0 && (m_phase % per) == per - 1;
      exp_now = pulse && m_cnt == 1;
      if (ref_stb && m_run != 0) m_phase = (m_phase + 1) % 32768;
      if (pulse) m_cnt = exp_now ? m_reload : m_cnt - 1;
      if (exp_now) m_irqs++;
      w = int'(wr_data);
      if (wr_en && wr_addr == 2 && w[0] && !exp_now) m_pend = 0;
      if (exp_now) m_pend = 1;
      if (wr_en && wr_addr == 0) begin
        nen = w & 1; nten = (w >> 8) & 1; nsel = (w >> 4) & 15;
        if (nsel != m_sel) m_phase = 0;
        if (nen == 1 && nten == 1 && m_ten == 0) begin
          m_run = 1; m_cnt = m_reload; m_phase = 0;
        end else if ((nten == 0 && m_ten == 1) || (nen == 0 && m_en == 1)) m_run = 0;
        m_en = nen; m_ten = nten; m_sel = nsel;
      end
      if (wr_en && wr_addr == 1 && w > 2) m_reload = w;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check("R2 ctrl", int'(ctrl_o), m_ten * 256 + m_sel * 16 + m_en);
      check("R3 reload", int'(reload_o), m_reload);
      check("R6 count", int'(count_o), m_cnt);
      check("R8 irq", int'(tick_irq), m_pend);
    end
  end

  // reference strobe every third cycle
  always @(negedge clk) ref_stb <= (cyc % 3 == 0);

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1; wr_addr = 2'(a); wr_data = CNT_W'(d);
    @(negedge clk); wr_en = 0; wr_data = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int held, irqs0;
    idle(4);
    // R1 reset state
    check("R1 ctrl", int'(ctrl_o), 0);
    check("R1 reload", int'(reload_o), 32);
    check("R1 count", int'(count_o), 0);
    check("R1 irq", int'(tick_irq), 0);
    rst_n = 1;
    idle(2);
    // R3 rejection and acceptance
    wr(1, 2);  check("R3 reject 2", int'(reload_o), 32);
    wr(1, 0);  check("R3 reject 0", int'(reload_o), 32);
    wr(1, 7);  check("R3 accept 7", int'(reload_o), 7);
    // R2 stray bits dropped
    wr(0, 'h0E01); check("R2 mask", int'(ctrl_o), 1);
    // R4 start
    wr(0, 'h101); check("R4 start load", int'(count_o), 7);
    irqs0 = m_irqs;
    idle(100);
    check("R7 ticks seen", int'(m_irqs > irqs0), 1);
    // R8 write of zero ignored, then clear
    wr(2, 0); check("R8 no-clear", int'(tick_irq), m_pend);
    wr(2, 1); check("R8 clear", int'(tick_irq), m_pend);
    // R9 select change while running
    wr(0, 'h121); check("R9 count after sel", int'(count_o), m_cnt);
    idle(300);
    // R5 stop by tick enable low
    wr(0, 'h021); held = int'(count_o); idle(50);
    check("R5 frozen tick-off", int'(count_o), held);
    // R5 stop by master low, R4 master return does not restart
    wr(0, 'h121); idle(40);
    wr(0, 'h120); held = int'(count_o); idle(30);
    check("R5 frozen master-off", int'(count_o), held);
    wr(0, 'h121); idle(50);
    check("R4 no restart", int'(count_o), held);
    // sel 0, short reload
    wr(0, 'h000); wr(1, 3); wr(0, 'h101);
    check("R4 restart", int'(count_o), 3);
    idle(60);
    wr(2, 1);
    idle(10);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule